// File: doc/BRIEF.md
# Host Bridge Outbound Address Translator

This block sits between a local 32-bit memory-mapped request port and a simplified parallel bus-master port. Local reads and writes that land in a fixed 1 GB window are turned into outbound bus transactions. Any request outside that window gets an error answer from the block itself and never reaches the bus. A small control register chooses how the window is used. In memory mode the outbound address keeps the low 30 bits of the local address and takes its top two bits from a control field. In configuration mode the local address is read as device, function and register fields. From these the block forms a device-select address with one bit set per device.

The block handles one transaction at a time. A bus cycle that ends in a master abort sets a sticky status flag, which software clears by writing one to it. An aborted read returns all-ones. Configuration requests that cannot be encoded are refused without any bus cycle, and so are requests aimed at the bridge's own slot. Two bits of the control register set the state of the bus reset pin.

Top module: `hb_xlate`

## Requirements
- R1: A local request is forwarded only when lcl_addr[31:30] is 2'b10 (0x8000_0000 to 0xBFFF_FFFF). Any other address starts no bus cycle. The request is answered one cycle after acceptance with lcl_ready=1, lcl_err=1 and lcl_rdata=0xFFFF_FFFF.
- R2: In memory mode the bus address is {ctrl[3:2], lcl_addr[29:0]} and bm_cfg=0. bm_we, bm_be and bm_wdata carry the local values unchanged.
- R3: Control bit 1 set selects configuration mode. Then device=lcl_addr[15:11], function=lcl_addr[10:8] and register=lcl_addr[7:0]. The bus address is (1<<(13+device)) | (function<<8) | (register & 0xFC), with bm_cfg=1.
- R4: A configuration request whose device is above 18, or whose formed address is 0x10_0000 or more, is refused as in R1 with no bus cycle.
- R5: A configuration request to device 3 (the bridge's own slot) is refused as in R1 with no bus cycle.
- R6: A bus completion with bm_abort=1 sets the sticky abort flag, which is status bit 26. A read that aborts returns 0xFFFF_FFFF with lcl_err=1.
- R7: Writing the status register with bit 26 set clears the abort flag. A write with bit 26 clear leaves it unchanged. A new abort in the same cycle as a clear wins.
- R8: ctrl[5:4] sets the reset pin. 0 releases it (bus_rst_oe=0), 1 drives it low, 2 drives it high, and 3 releases it.
- R9: Only one transaction is outstanding. bm_req stays high with stable address and controls until bm_ack. A lcl_req that arrives while a transaction is pending is ignored.
- R10: lcl_ready is a single-cycle pulse in the cycle after bm_ack. A successful completion returns bm_rdata with lcl_err=0.
- R11: With reg_sel=0, reg_rdata shows ctrl bits 5:1 in place and all other bits zero. With reg_sel=1 it shows the abort flag at bit 26 and zeros elsewhere. Both values are reset to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lcl_req | input | 1 | Local request strobe, one cycle |
| lcl_we | input | 1 | Local write (1) or read (0) |
| lcl_addr | input | 32 | Local address |
| lcl_be | input | 4 | Local byte enables |
| lcl_wdata | input | 32 | Local write data |
| lcl_ready | output | 1 | Completion pulse |
| lcl_err | output | 1 | Completion refused or aborted |
| lcl_rdata | output | 32 | Read data returned with lcl_ready |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register value |
| bm_req | output | 1 | Outbound transaction pending |
| bm_cfg | output | 1 | Configuration (1) or memory (0) cycle |
| bm_we | output | 1 | Outbound write |
| bm_addr | output | 32 | Outbound address |
| bm_be | output | 4 | Outbound byte enables |
| bm_wdata | output | 32 | Outbound write data |
| bm_ack | input | 1 | Bus completion |
| bm_abort | input | 1 | Completion ended in master abort |
| bm_rdata | input | 32 | Bus read data |
| bus_rst_oe | output | 1 | Reset pin output enable |
| bus_rst_drv | output | 1 | Reset pin level when enabled |

## Verification
Each result arrives a fixed number of cycles after its stimulus. bm_req and its fields appear one cycle after a request is accepted. A refused request gets lcl_ready one cycle after acceptance. A forwarded one gets lcl_ready one cycle after bm_ack, and lcl_ready drops again the cycle after that. Register readback and reset-pin levels follow a register write in the next cycle. The bench drives every input on the falling edge and samples each result on the falling edge of exactly the cycle worked out above. An expected value taken one cycle early or late therefore shows up as a mismatch.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;
    localparam int DW        = 32;
    localparam int BEW       = DW / 8;
    localparam int DEV_W     = 5;
    localparam int FN_W      = 3;
    localparam int REG_W     = 8;
    localparam int SEL_BASE  = 13;
    localparam int MAX_DEV   = 18;
    localparam int HOST_SLOT = 3;
    localparam int CFG_LIMIT = 20;
    localparam int ABORT_BIT = 26;
    localparam int CTRL_W    = 6;
    localparam logic [CTRL_W-1:0] CTRL_MASK = 6'b111110;
    localparam logic [1:0] WIN_TAG = 2'b10;

    typedef enum logic [0:0] {ST_IDLE, ST_BUS} hb_st_e;

    typedef struct packed {
        hb_st_e            st;
        logic [CTRL_W-1:0] ctrl;
        logic              abort;
        logic              rdy;
        logic              err;
        logic [DW-1:0]     rdata;
        logic              cfg;
        logic              we;
        logic [DW-1:0]     addr;
        logic [BEW-1:0]    be;
        logic [DW-1:0]     wdata;
    } hb_state_t;
endpackage

// File: rtl/hb_cfg_addr.sv
`timescale 1ns/1ps
module hb_cfg_addr
    import hb_pkg::*;
#(
    parameter int SEL_W = 64
) (
    input  logic [DEV_W-1:0] dev,
    input  logic [FN_W-1:0]  fn,
    input  logic [REG_W-1:0] regoff,
    output logic [DW-1:0]    cfg_addr,
    output logic             cfg_bad
);
    localparam int SH_W = $clog2(SEL_W);

    logic [SEL_W-1:0] sel_wide;
    logic [SEL_W-1:0] full;

    always_comb begin
        sel_wide = {{(SEL_W-1){1'b0}}, 1'b1} << (SH_W'(SEL_BASE) + SH_W'(dev));
        full     = sel_wide
                 | (SEL_W'(fn) << REG_W)
                 | SEL_W'({regoff[REG_W-1:2], 2'b00});
        cfg_addr = full[DW-1:0];
        cfg_bad  = (int'(dev) > MAX_DEV) || (|full[SEL_W-1:CFG_LIMIT])
                 || (int'(dev) == HOST_SLOT);
    end
endmodule

// File: rtl/hb_route.sv
`timescale 1ns/1ps
module hb_route
    import hb_pkg::*;
(
    input  logic [DW-1:0] addr,
    input  logic          cfg_mode,
    input  logic [1:0]    hi_bits,
    output logic          fwd,
    output logic [DW-1:0] out_addr
);
    logic [DW-1:0] cfg_addr;
    logic          cfg_bad;

    hb_cfg_addr u_cfg (
        .dev     (addr[REG_W+FN_W +: DEV_W]),
        .fn      (addr[REG_W +: FN_W]),
        .regoff  (addr[REG_W-1:0]),
        .cfg_addr(cfg_addr),
        .cfg_bad (cfg_bad)
    );

    always_comb begin
        fwd      = (addr[DW-1:DW-2] == WIN_TAG) && !(cfg_mode && cfg_bad);
        out_addr = cfg_mode ? cfg_addr : {hi_bits, addr[DW-3:0]};
    end
endmodule

// File: rtl/hb_rst_pin.sv
`timescale 1ns/1ps
module hb_rst_pin (
    input  logic [1:0] mode,
    output logic       oe,
    output logic       drv
);
    always_comb begin
        oe  = 1'b0;
        drv = 1'b0;
        case (mode)
            2'd1: oe = 1'b1;
            2'd2: begin oe = 1'b1; drv = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/hb_xlate.sv
`timescale 1ns/1ps
module hb_xlate
    import hb_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lcl_req,
    input  logic           lcl_we,
    input  logic [DW-1:0]  lcl_addr,
    input  logic [BEW-1:0] lcl_be,
    input  logic [DW-1:0]  lcl_wdata,
    output logic           lcl_ready,
    output logic           lcl_err,
    output logic [DW-1:0]  lcl_rdata,
    input  logic           reg_wr,
    input  logic           reg_sel,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           bm_req,
    output logic           bm_cfg,
    output logic           bm_we,
    output logic [DW-1:0]  bm_addr,
    output logic [BEW-1:0] bm_be,
    output logic [DW-1:0]  bm_wdata,
    input  logic           bm_ack,
    input  logic           bm_abort,
    input  logic [DW-1:0]  bm_rdata,
    output logic           bus_rst_oe,
    output logic           bus_rst_drv
);
    hb_state_t s_q, s_d;
    logic          fwd;
    logic [DW-1:0] out_addr;
    logic          abort_flag;

    hb_route u_route (
        .addr    (lcl_addr),
        .cfg_mode(s_q.ctrl[1]),
        .hi_bits (s_q.ctrl[3:2]),
        .fwd     (fwd),
        .out_addr(out_addr)
    );

    hb_rst_pin u_rst (
        .mode(s_q.ctrl[5:4]),
        .oe  (bus_rst_oe),
        .drv (bus_rst_drv)
    );

    always_comb begin
        s_d     = s_q;
        s_d.rdy = 1'b0;
        if (reg_wr && !reg_sel)
            s_d.ctrl = reg_wdata[CTRL_W-1:0] & CTRL_MASK;
        if (reg_wr && reg_sel && reg_wdata[ABORT_BIT])
            s_d.abort = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (lcl_req) begin
                    if (fwd) begin
                        s_d.st    = ST_BUS;
                        s_d.cfg   = s_q.ctrl[1];
                        s_d.we    = lcl_we;
                        s_d.addr  = out_addr;
                        s_d.be    = lcl_be;
                        s_d.wdata = lcl_wdata;
                    end else begin
                        s_d.rdy   = 1'b1;
                        s_d.err   = 1'b1;
                        s_d.rdata = '1;
                    end
                end
            end
            ST_BUS: begin
                if (bm_ack) begin
                    s_d.st    = ST_IDLE;
                    s_d.rdy   = 1'b1;
                    s_d.err   = bm_abort;
                    s_d.rdata = bm_abort ? '1 : bm_rdata;
                    if (bm_abort)
                        s_d.abort = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign abort_flag = s_q.abort;
    assign lcl_ready  = s_q.rdy;
    assign lcl_err    = s_q.err;
    assign lcl_rdata  = s_q.rdata;
    assign bm_req     = (s_q.st == ST_BUS);
    assign bm_cfg     = s_q.cfg;
    assign bm_we      = s_q.we;
    assign bm_addr    = s_q.addr;
    assign bm_be      = s_q.be;
    assign bm_wdata   = s_q.wdata;
    assign reg_rdata  = reg_sel ? (DW'(s_q.abort) << ABORT_BIT)
                                : DW'(s_q.ctrl);
endmodule

// File: rtl/hb_xlate_chk.sv
`timescale 1ns/1ps
module hb_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bm_req,
    input logic        bm_ack,
    input logic        bm_abort,
    input logic        bm_we,
    input logic        bm_cfg,
    input logic [31:0] bm_addr,
    input logic        lcl_ready,
    input logic        lcl_err,
    input logic [31:0] lcl_rdata,
    input logic        reg_wr,
    input logic        reg_sel,
    input logic [31:0] reg_wdata,
    input logic        abort_flag
);
    p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bm_req && !bm_ack |=> bm_req && $stable(bm_addr) && $stable(bm_we));

    p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bm_req && lcl_ready));

    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_ready |=> !lcl_ready);

    p_abort_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bm_req && bm_ack && bm_abort |=> abort_flag && lcl_err);

    p_abort_rdata_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bm_req && bm_ack && bm_abort && !bm_we |=> lcl_rdata == 32'hFFFF_FFFF);

    p_abort_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_flag && !(reg_wr && reg_sel && reg_wdata[26]) |=> abort_flag);

    p_cfg_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bm_req && bm_cfg |-> bm_addr < 32'h0010_0000);
endmodule

bind hb_xlate hb_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bm_req    (bm_req),
    .bm_ack    (bm_ack),
    .bm_abort  (bm_abort),
    .bm_we     (bm_we),
    .bm_cfg    (bm_cfg),
    .bm_addr   (bm_addr),
    .lcl_ready (lcl_ready),
    .lcl_err   (lcl_err),
    .lcl_rdata (lcl_rdata),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .abort_flag(abort_flag)
);

// File: tb/hb_xlate_bench.sv
`timescale 1ns/1ps
module hb_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lcl_req = 1'b0, lcl_we = 1'b0;
    logic [31:0] lcl_addr = '0, lcl_wdata = '0;
    logic [3:0]  lcl_be = '0;
    logic        lcl_ready, lcl_err;
    logic [31:0] lcl_rdata;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        bm_req, bm_cfg, bm_we;
    logic [31:0] bm_addr, bm_wdata;
    logic [3:0]  bm_be;
    logic        bm_ack = 1'b0, bm_abort = 1'b0;
    logic [31:0] bm_rdata = '0;
    logic        bus_rst_oe, bus_rst_drv;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [5:0] ctrl_m = '0;
    logic       abort_m = 1'b0;

    always #2.5 clk = ~clk;

    hb_xlate u_hb_xlate (.*);

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic expect_route(input logic [31:0] a, input logic [5:0] c,
                                          output logic [31:0] ea);
        logic [63:0] f;
        int dev;
        ea = '0;
        if (a[31:30] != 2'b10) return 1'b0;
        if (!c[1]) begin
            ea = {c[3:2], a[29:0]};
            return 1'b1;
        end
        dev = int'(a[15:11]);
        if (dev > 18 || dev == 3) return 1'b0;
        f = (64'd1 << (13 + dev)) | (64'(a[10:8]) << 8) | 64'(a[7:0] & 8'hFC);
        if (f >= 64'h10_0000) return 1'b0;
        ea = f[31:0];
        return 1'b1;
    endfunction

    task automatic reg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (!sel) ctrl_m = d[5:0] & 6'b111110;
        else if (d[26]) abort_m = 1'b0;
    endtask

    task automatic reg_check(input logic sel, input string req);
        logic [31:0] e;
        reg_sel = sel;
        #1;
        e = sel ? (32'(abort_m) << 26) : 32'(ctrl_m);
        chk(reg_rdata == e, req, reg_rdata, e);
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                          input logic [3:0] be, input int dly, input logic ab,
                          input logic [31:0] rd, input string req);
        logic [31:0] ea;
        logic fwd;
        fwd = expect_route(a, ctrl_m, ea);
        @(negedge clk);
        lcl_req = 1'b1; lcl_we = we; lcl_addr = a; lcl_wdata = wd; lcl_be = be;
        @(negedge clk);
        lcl_req = 1'b0;
        if (fwd) begin
            chk(bm_req == 1'b1, {req, " bm_req"}, 32'(bm_req), 1);
            chk(bm_addr == ea, {req, " bm_addr"}, bm_addr, ea);
            chk(bm_cfg == ctrl_m[1] && bm_we == we, {req, " cfg/we"}, {bm_cfg, bm_we}, {ctrl_m[1], we});
            chk(bm_be == be && bm_wdata == wd, {req, " R2 be/wdata"}, bm_wdata, wd);
            for (int i = 0; i < dly; i++) begin
                @(negedge clk);
                chk(bm_req && bm_addr == ea && !lcl_ready, "R9 held", bm_addr, ea);
            end
            bm_ack = 1'b1; bm_abort = ab; bm_rdata = rd;
            @(negedge clk);
            bm_ack = 1'b0; bm_abort = 1'b0;
            chk(lcl_ready && lcl_err == ab, {req, " R10 ready/err"}, {lcl_ready, lcl_err}, {1'b1, ab});
            if (!we)
                chk(lcl_rdata == (ab ? 32'hFFFF_FFFF : rd), {req, " R6/R10 rdata"},
                    lcl_rdata, ab ? 32'hFFFF_FFFF : rd);
            if (ab) abort_m = 1'b1;
        end else begin
            chk(!bm_req, {req, " R1 no bus cycle"}, 32'(bm_req), 0);
            chk(lcl_ready && lcl_err && lcl_rdata == 32'hFFFF_FFFF, {req, " R1 refuse"},
                lcl_rdata, 32'hFFFF_FFFF);
        end
        @(negedge clk);
        chk(!lcl_ready && !bm_req, "R10 pulse ends", 32'(lcl_ready), 0);
    endtask

    initial begin
        logic [31:0] a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state R11
        chk(!lcl_ready && !bm_req && !bus_rst_oe, "R11 reset outputs", {lcl_ready, bm_req, bus_rst_oe}, 0);
        reg_check(1'b0, "R11 ctrl reset");
        reg_check(1'b1, "R11 status reset");

        // R8 reset pin modes
        reg_write(1'b0, 32'h10);
        chk(bus_rst_oe && !bus_rst_drv, "R8 drive low", {bus_rst_oe, bus_rst_drv}, 2'b10);
        reg_write(1'b0, 32'h20);
        chk(bus_rst_oe && bus_rst_drv, "R8 drive high", {bus_rst_oe, bus_rst_drv}, 2'b11);
        reg_write(1'b0, 32'h30);
        chk(!bus_rst_oe, "R8 mode 3 released", 32'(bus_rst_oe), 0);
        reg_write(1'b0, 32'hFFFF_FFFF);
        reg_check(1'b0, "R11 ctrl mask");

        // R2 memory mode, hi bits 01
        reg_write(1'b0, 32'h24);
        access(1'b0, 32'h8123_4567, 32'h0, 4'b0011, 2, 1'b0, 32'hCAFE_0001, "R2 mem read");
        access(1'b1, 32'hBFFF_FFFC, 32'h1234_5678, 4'b1000, 0, 1'b0, 32'h0, "R2 mem write");
        // R1 window edges
        access(1'b0, 32'h7FFF_FFFF, 32'h0, 4'hF, 0, 1'b0, 32'h0, "R1 below");
        access(1'b0, 32'hC000_0000, 32'h0, 4'hF, 0, 1'b0, 32'h0, "R1 above");
        access(1'b0, 32'h8000_0000, 32'h0, 4'hF, 1, 1'b0, 32'h5A5A_5A5A, "R1 base");

        // R3 configuration mode
        reg_write(1'b0, 32'h22);
        access(1'b0, 32'h8000_0513, 32'h0, 4'hF, 1, 1'b0, 32'h1111_2222, "R3 cfg dev0");
        chk(bm_addr == 32'h0000_2510, "R3 dev0 addr", bm_addr, 32'h2510);
        access(1'b1, 32'h8000_3000 | 32'h0FC, 32'hABCD, 4'hF, 0, 1'b0, 32'h0, "R3 cfg dev6");
        chk(bm_addr == 32'h0008_00FC, "R3 dev6 addr", bm_addr, 32'h0008_00FC);
        access(1'b0, 32'h8000_3800, 32'h0, 4'hF, 0, 1'b0, 32'h0, "R4 dev7");
        access(1'b0, 32'h8000_9800, 32'h0, 4'hF, 0, 1'b0, 32'h0, "R4 dev19");
        access(1'b0, 32'h8000_1800, 32'h0, 4'hF, 0, 1'b0, 32'h0, "R5 host slot");

        // R6 abort and R7 clear
        access(1'b0, 32'h8000_1000, 32'h0, 4'hF, 2, 1'b1, 32'h1234_0000, "R6 abort read");
        reg_check(1'b1, "R6 status set");
        reg_write(1'b1, 32'h0400_0000 ^ 32'hFFFF_FFFF);
        reg_check(1'b1, "R7 no clear without bit");
        reg_write(1'b1, 32'h0400_0000);
        reg_check(1'b1, "R7 cleared");

        // R9 ignored request while busy
        reg_write(1'b0, 32'h0);
        @(negedge clk);
        lcl_req = 1'b1; lcl_we = 1'b0; lcl_addr = 32'h8000_0040;
        @(negedge clk);
        lcl_addr = 32'h9000_0080;
        @(negedge clk);
        lcl_req = 1'b0;
        chk(bm_addr == 32'h0000_0040, "R9 busy request ignored", bm_addr, 32'h40);
        bm_ack = 1'b1; bm_rdata = 32'h77;
        @(negedge clk);
        bm_ack = 1'b0;
        chk(lcl_ready && lcl_rdata == 32'h77, "R9 single completion", lcl_rdata, 32'h77);
        @(negedge clk);
        chk(!bm_req && !lcl_ready, "R9 no second cycle", {bm_req, lcl_ready}, 0);

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [31:0] r;
            r = $urandom();
            if (n % 40 == 0) reg_write(1'b0, $urandom());
            a = (r[3:0] < 4'd12) ? {2'b10, r[29:0]} : r;
            if (ctrl_m[1] && r[4]) a[15:11] = 5'($urandom_range(0, 8));
            access(r[5], a, $urandom(), 4'($urandom()), int'($urandom_range(0, 3)),
                   ($urandom_range(0, 7) == 0), $urandom(), "R1/R2/R3 random");
            if (abort_m) begin
                reg_check(1'b1, "R6 random status");
                reg_write(1'b1, 32'h0400_0000);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
    end
endmodule